// File: doc/BRIEF.md
# Audio slot sample word packer

This block sits between four DMA request channels and the per-frame slot data of an AC'97-style serial frame. Each channel moves 32-bit words, and each slot carries one 16-bit sample in a 20-bit field. On transmit, the block splits each word into samples and presents them as slot values for the next frame. On receive, it collects slot samples and assembles them into words. Serial shifting, frame sync generation, FIFO storage and the DMA controller are outside the block.

A 2-bit channel select picks one of four fixed patterns. Each pattern assigns the four channels to streams, and the stream fixes the slots a channel uses and how its samples are packed:

- Stereo pair: left and right samples share one word.
- Microphone: one valid sample per word, with the other half zero.
- Mono packed: two consecutive samples share one word.

A byte-order input selects which 16-bit half of a word sits at the lower memory address. One `frame_tick` pulse marks each frame. On that cycle, transmit words are taken and receive slots are sampled.

Top module: `slot_packer`

## Requirements
- R1: A transmitted slot carries its 16-bit sample in bits [19:4] with bits [3:0] zero. A received slot contributes only bits [19:4], and bits [3:0] are ignored.
- R2: A stereo transmit channel (PCM out on slots 3/4, surround out on slots 7/8) raises `tx_ready` on every `frame_tick`. When `tx_valid` is high, it takes one word per frame. The lower-address half goes to the left slot (3 or 7) and the other half to the right slot (4 or 8). The slots show the new values from the cycle after the tick.
- R3: A mono transmit channel (center slot 6, LFE slot 9, modem out slot 5) takes a word only on ticks where no later sample is still held. On that frame it sends the lower-address half. On the next frame it sends the other half with `tx_ready` low.
- R4: With `big_endian` = 0, the lower-address sample is word bits [15:0]. With `big_endian` = 1, it is bits [31:16].
- R5: A stereo receive channel (PCM in, slots 3/4) builds a word with slot 3 in the lower-address half and slot 4 in the other half. `rx_valid` rises in the cycle after the tick.
- R6: A microphone receive channel (slot 6) places its sample in the lower-address half and zero in the other half.
- R7: A mono receive channel (modem in, slot 5) produces a word only every second accepted frame. The earlier sample goes in the lower-address half.
- R8: While `rx_valid` is high and `rx_ready` is low, `rx_word` holds steady and a frame tick is ignored by that channel. When `rx_valid` and `rx_ready` are both high without a tick, `rx_valid` falls next cycle.
- R9: Stream per channel (ch0, ch1, ch2, ch3) for each `chan_sel` value:
  - 0: PCM out, PCM in, center out, LFE out
  - 1: PCM out, PCM in, surround out, modem in
  - 2: PCM out, mic in, modem out, modem in
  - 3: PCM out, PCM in, modem out, mic in
- R10: A transmit channel that has no word and no held sample on a tick sends zero on its slots. A slot that no channel drives reads zero. `tx_slot` packs slot 3 at bits [19:0] up to slot 9 at bits [139:120]. `rx_slot` uses the same layout.
- R11: After reset, all slots read zero, `rx_valid` is low and no sample is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| big_endian | input | 1 | Byte order: 1 places the lower-address sample in bits [31:16] |
| chan_sel | input | 2 | Channel-to-stream pattern select |
| frame_tick | input | 1 | One-cycle pulse per frame |
| tx_word | input | 128 | Transmit words, channel c at bits [32c+31:32c] |
| tx_valid | input | 4 | Transmit word valid per channel |
| tx_ready | output | 4 | Transmit word taken per channel (only on a tick) |
| rx_word | output | 128 | Received words, channel c at bits [32c+31:32c] |
| rx_valid | output | 4 | Received word valid per channel |
| rx_ready | input | 4 | Downstream accepts the received word |
| rx_slot | input | 140 | Received slots 3..9, 20 bits each |
| tx_slot | output | 140 | Transmit slots 3..9, 20 bits each |

## Verification
`tx_ready` is combinational and is due in the tick cycle itself. Transmit slot values and received words are registered once, so they are due in the cycle after the tick. A mono receive word is due only after its second accepted frame. The bench drives each cycle's inputs just after a falling edge and checks `tx_ready` one time unit later. It then advances a queue-based model and compares the registered outputs at the next falling edge, one full edge after the stimulus that caused them.

// File: rtl/slot_packer_pkg.sv
package slot_packer_pkg;
    localparam int NCH        = 4;
    localparam int SAMP_W     = 16;
    localparam int SLOT_W     = 20;
    localparam int WORD_W     = 2 * SAMP_W;
    localparam int FIRST_SLOT = 3;
    localparam int NSLOT      = 7;
    localparam int PAD_W      = SLOT_W - SAMP_W;

    typedef enum logic [2:0] {
        ST_PCM_OUT, ST_CENTER, ST_SURR, ST_LFE,
        ST_MDM_OUT, ST_PCM_IN, ST_MIC_IN, ST_MDM_IN
    } stream_e;

    typedef enum logic [1:0] { PK_PAIR, PK_MIC, PK_MONO } pack_e;

    typedef struct packed {
        logic              hold_v;
        logic [SAMP_W-1:0] hold;
        logic [SAMP_W-1:0] out_a;
        logic [SAMP_W-1:0] out_b;
        logic [WORD_W-1:0] rword;
        logic              rvalid;
        logic              rhalf;
        logic [SAMP_W-1:0] rfirst;
    } lane_st_t;

    function automatic stream_e chan_stream(input logic [1:0] sel, input logic [1:0] ch);
        stream_e s;
        s = ST_PCM_OUT;
        case (ch)
            2'd0: s = ST_PCM_OUT;
            2'd1: s = (sel == 2'd2) ? ST_MIC_IN : ST_PCM_IN;
            2'd2: case (sel)
                      2'd0:    s = ST_CENTER;
                      2'd1:    s = ST_SURR;
                      default: s = ST_MDM_OUT;
                  endcase
            default: case (sel)
                      2'd0:    s = ST_LFE;
                      2'd3:    s = ST_MIC_IN;
                      default: s = ST_MDM_IN;
                  endcase
        endcase
        return s;
    endfunction

    function automatic logic is_tx(input stream_e s);
        return (s == ST_PCM_OUT) || (s == ST_CENTER) || (s == ST_SURR) ||
               (s == ST_LFE) || (s == ST_MDM_OUT);
    endfunction

    function automatic pack_e stream_pack(input stream_e s);
        pack_e p;
        case (s)
            ST_PCM_OUT, ST_SURR, ST_PCM_IN: p = PK_PAIR;
            ST_MIC_IN:                      p = PK_MIC;
            default:                        p = PK_MONO;
        endcase
        return p;
    endfunction

    // zero-based slot index (slot number minus FIRST_SLOT)
    function automatic logic [2:0] slot_a(input stream_e s);
        logic [2:0] i;
        case (s)
            ST_PCM_OUT, ST_PCM_IN:  i = 3'd0;
            ST_MDM_OUT, ST_MDM_IN:  i = 3'd2;
            ST_CENTER, ST_MIC_IN:   i = 3'd3;
            ST_SURR:                i = 3'd4;
            default:                i = 3'd6;
        endcase
        return i;
    endfunction

    function automatic logic [2:0] slot_b(input stream_e s);
        logic [2:0] i;
        case (s)
            ST_PCM_OUT, ST_PCM_IN: i = 3'd1;
            ST_SURR:               i = 3'd5;
            default:               i = slot_a(s);
        endcase
        return i;
    endfunction
endpackage

// File: rtl/slot_packer_lane.sv
module slot_packer_lane
    import slot_packer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              big_endian,
    input  stream_e           stream,
    input  logic              frame_tick,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_valid,
    input  logic              rx_ready,
    input  logic [SLOT_W-1:0] slot_a_in,
    input  logic [SLOT_W-1:0] slot_b_in,
    output logic [SAMP_W-1:0] samp_a,
    output logic [SAMP_W-1:0] samp_b
);
    lane_st_t st_d, st_q;
    logic [SAMP_W-1:0] lo_half, hi_half, rx_sa, rx_sb;
    logic tx_dir, take;
    pack_e pk;

    function automatic logic [WORD_W-1:0] pack2(input logic be,
                                                input logic [SAMP_W-1:0] first,
                                                input logic [SAMP_W-1:0] second);
        return be ? {first, second} : {second, first};
    endfunction

    always_comb begin
        st_d     = st_q;
        tx_ready = 1'b0;
        tx_dir   = is_tx(stream);
        pk       = stream_pack(stream);
        lo_half  = big_endian ? tx_word[WORD_W-1 -: SAMP_W] : tx_word[SAMP_W-1:0];
        hi_half  = big_endian ? tx_word[SAMP_W-1:0] : tx_word[WORD_W-1 -: SAMP_W];
        rx_sa    = slot_a_in[SLOT_W-1 -: SAMP_W];
        rx_sb    = slot_b_in[SLOT_W-1 -: SAMP_W];
        take     = !st_q.rvalid || rx_ready;

        if (frame_tick && tx_dir) begin
            st_d.out_b = '0;
            if (st_q.hold_v) begin
                st_d.out_a  = st_q.hold;
                st_d.hold_v = 1'b0;
            end else begin
                tx_ready = 1'b1;
                if (!tx_valid) begin
                    st_d.out_a = '0;
                end else if (pk == PK_PAIR) begin
                    st_d.out_a = lo_half;
                    st_d.out_b = hi_half;
                end else begin
                    st_d.out_a  = lo_half;
                    st_d.hold   = hi_half;
                    st_d.hold_v = 1'b1;
                end
            end
        end

        if (st_q.rvalid && rx_ready) st_d.rvalid = 1'b0;
        if (frame_tick && !tx_dir && take) begin
            case (pk)
                PK_PAIR: begin
                    st_d.rword  = pack2(big_endian, rx_sa, rx_sb);
                    st_d.rvalid = 1'b1;
                end
                PK_MIC: begin
                    st_d.rword  = pack2(big_endian, rx_sa, '0);
                    st_d.rvalid = 1'b1;
                end
                default: begin
                    if (!st_q.rhalf) begin
                        st_d.rfirst = rx_sa;
                        st_d.rhalf  = 1'b1;
                    end else begin
                        st_d.rword  = pack2(big_endian, st_q.rfirst, rx_sa);
                        st_d.rvalid = 1'b1;
                        st_d.rhalf  = 1'b0;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rx_word  = st_q.rword;
    assign rx_valid = st_q.rvalid;
    assign samp_a   = st_q.out_a;
    assign samp_b   = st_q.out_b;
endmodule

// File: rtl/slot_packer_router.sv
module slot_packer_router
    import slot_packer_pkg::*;
(
    input  stream_e                    stream [NCH],
    input  logic [NCH-1:0][SAMP_W-1:0] samp_a,
    input  logic [NCH-1:0][SAMP_W-1:0] samp_b,
    input  logic [NSLOT*SLOT_W-1:0]    rx_slot,
    output logic [NSLOT*SLOT_W-1:0]    tx_slot,
    output logic [NCH-1:0][SLOT_W-1:0] lane_a_in,
    output logic [NCH-1:0][SLOT_W-1:0] lane_b_in
);
    always_comb begin
        tx_slot = '0;
        for (int c = 0; c < NCH; c++) begin
            lane_a_in[c] = rx_slot[32'(slot_a(stream[c])) * SLOT_W +: SLOT_W];
            lane_b_in[c] = rx_slot[32'(slot_b(stream[c])) * SLOT_W +: SLOT_W];
            if (is_tx(stream[c])) begin
                tx_slot[32'(slot_a(stream[c])) * SLOT_W +: SLOT_W] = {samp_a[c], {PAD_W{1'b0}}};
                if (stream_pack(stream[c]) == PK_PAIR)
                    tx_slot[32'(slot_b(stream[c])) * SLOT_W +: SLOT_W] = {samp_b[c], {PAD_W{1'b0}}};
            end
        end
    end
endmodule

// File: rtl/slot_packer.sv
module slot_packer
    import slot_packer_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    big_endian,
    input  logic [1:0]              chan_sel,
    input  logic                    frame_tick,
    input  logic [NCH*WORD_W-1:0]   tx_word,
    input  logic [NCH-1:0]          tx_valid,
    output logic [NCH-1:0]          tx_ready,
    output logic [NCH*WORD_W-1:0]   rx_word,
    output logic [NCH-1:0]          rx_valid,
    input  logic [NCH-1:0]          rx_ready,
    input  logic [NSLOT*SLOT_W-1:0] rx_slot,
    output logic [NSLOT*SLOT_W-1:0] tx_slot
);
    stream_e                    stream [NCH];
    logic [NCH-1:0][SAMP_W-1:0] samp_a, samp_b;
    logic [NCH-1:0][SLOT_W-1:0] lane_a_in, lane_b_in;

    for (genvar c = 0; c < NCH; c++) begin : g_lane
        assign stream[c] = chan_stream(chan_sel, 2'(c));
        slot_packer_lane lane_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .big_endian (big_endian),
            .stream     (stream[c]),
            .frame_tick (frame_tick),
            .tx_word    (tx_word[c*WORD_W +: WORD_W]),
            .tx_valid   (tx_valid[c]),
            .tx_ready   (tx_ready[c]),
            .rx_word    (rx_word[c*WORD_W +: WORD_W]),
            .rx_valid   (rx_valid[c]),
            .rx_ready   (rx_ready[c]),
            .slot_a_in  (lane_a_in[c]),
            .slot_b_in  (lane_b_in[c]),
            .samp_a     (samp_a[c]),
            .samp_b     (samp_b[c])
        );
    end

    slot_packer_router router_i (
        .stream    (stream),
        .samp_a    (samp_a),
        .samp_b    (samp_b),
        .rx_slot   (rx_slot),
        .tx_slot   (tx_slot),
        .lane_a_in (lane_a_in),
        .lane_b_in (lane_b_in)
    );
endmodule

// File: rtl/slot_packer_chk.sv
module slot_packer_chk
    import slot_packer_pkg::*;
(
    input logic                    clk,
    input logic                    rst_n,
    input logic                    frame_tick,
    input logic [1:0]              chan_sel,
    input logic [NCH-1:0]          tx_ready,
    input logic [NCH-1:0]          rx_valid,
    input logic [NCH-1:0]          rx_ready,
    input logic [NCH*WORD_W-1:0]   rx_word,
    input logic [NSLOT*SLOT_W-1:0] tx_slot
);
    // R2: slots change only in the cycle after a tick (for a fixed pattern)
    assert_slot_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(frame_tick) && $stable(chan_sel)) |-> $stable(tx_slot));

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        // R3: a word is taken only on a tick
        assert_ready_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
            tx_ready[c] |-> frame_tick);
        // R5: a received word appears only after a tick
        assert_rx_after_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rx_valid[c]) |-> $past(frame_tick));
        // R8: stalled word is held unchanged
        assert_rx_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (rx_valid[c] && !rx_ready[c]) |=>
                (rx_valid[c] && $stable(rx_word[c*WORD_W +: WORD_W])));
        // R8: an accepted word without a new tick leaves the output empty
        assert_rx_drain_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (rx_valid[c] && rx_ready[c] && !frame_tick) |=> !rx_valid[c]);
    end
endmodule

bind slot_packer slot_packer_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_tick (frame_tick),
    .chan_sel   (chan_sel),
    .tx_ready   (tx_ready),
    .rx_valid   (rx_valid),
    .rx_ready   (rx_ready),
    .rx_word    (rx_word),
    .tx_slot    (tx_slot)
);

// File: tb/slot_packer_tb_top.sv
`timescale 1ns/1ps
module slot_packer_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         big_endian = 1'b0;
    logic [1:0]   chan_sel = 2'd0;
    logic         frame_tick = 1'b0;
    logic [127:0] tx_word = '0;
    logic [3:0]   tx_valid = '0;
    logic [3:0]   tx_ready;
    logic [127:0] rx_word;
    logic [3:0]   rx_valid;
    logic [3:0]   rx_ready = '0;
    logic [139:0] rx_slot = '0;
    logic [139:0] tx_slot;

    int vectors = 0, miscompares = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    slot_packer dut_i (.*);

    // reference model state
    logic [31:0] wq   [4][$];
    logic [15:0] sq   [4][$];
    logic [15:0] rq   [4][$];
    logic [15:0] cur_a[4], cur_b[4];
    logic        exp_rv[4];
    logic [31:0] exp_rw[4];

    // stream codes: 0 pcm out,1 center,2 surround,3 lfe,4 modem out,5 pcm in,6 mic,7 modem in (R9)
    function automatic int strm(int sel, int ch);
        int t[4][4] = '{'{0,5,1,3}, '{0,5,2,7}, '{0,6,4,7}, '{0,5,4,6}};
        return t[sel][ch];
    endfunction
    function automatic bit s_tx(int s);   return s < 5; endfunction
    function automatic bit s_pair(int s); return s == 0 || s == 2 || s == 5; endfunction
    function automatic int s_slota(int s);
        case (s) 0, 5: return 3; 1, 6: return 6; 2: return 7; 3: return 9; default: return 5; endcase
    endfunction
    function automatic int s_slotb(int s); return (s == 2) ? 8 : 4; endfunction
    function automatic string tx_tag(int s);
        return s_pair(s) ? "R2 R1 R4" : "R3 R1 R4";
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_regs(string pre);
        for (int s = 3; s <= 9; s++) begin
            logic [19:0] e = '0;
            string tag = "R10";
            for (int c = 0; c < 4; c++) begin
                int st = strm(chan_sel, c);
                if (s_tx(st) && s_slota(st) == s) begin e = {cur_a[c], 4'h0}; tag = tx_tag(st); end
                if (s_tx(st) && s_pair(st) && s_slotb(st) == s) begin e = {cur_b[c], 4'h0}; tag = tx_tag(st); end
            end
            chk($sformatf("%s%s slot %0d", pre, tag, s), 32'(tx_slot[(s-3)*20 +: 20]), 32'(e));
        end
        for (int c = 0; c < 4; c++) begin
            int st = strm(chan_sel, c);
            string tag = (st == 5) ? "R5" : (st == 6) ? "R6" : "R7";
            chk($sformatf("%sR8 rx_valid ch%0d", pre, c), 32'(rx_valid[c]), 32'(exp_rv[c]));
            if (exp_rv[c])
                chk($sformatf("%s%s R4 rx_word ch%0d", pre, tag, c), rx_word[c*32 +: 32], exp_rw[c]);
        end
    endtask

    function automatic logic [31:0] pk(logic [15:0] first, logic [15:0] second);
        return big_endian ? {first, second} : {second, first};
    endfunction

    task automatic model_reset();
        for (int c = 0; c < 4; c++) begin
            wq[c].delete(); sq[c].delete(); rq[c].delete();
            cur_a[c] = '0; cur_b[c] = '0; exp_rv[c] = 0; exp_rw[c] = '0;
        end
    endtask

    task automatic step(bit tick, logic [3:0] rdy, string pre = "");
        compare_regs(pre);
        frame_tick = tick;
        rx_ready   = rdy;
        if (tick) for (int s = 0; s < 7; s++) rx_slot[s*20 +: 20] = 20'($urandom);
        for (int c = 0; c < 4; c++) begin
            tx_valid[c] = wq[c].size() > 0;
            tx_word[c*32 +: 32] = (wq[c].size() > 0) ? wq[c][0] : 32'h0;
        end
        #1;
        for (int c = 0; c < 4; c++) begin
            int st = strm(chan_sel, c);
            bit er = tick && s_tx(st) && (s_pair(st) || sq[c].size() == 0);
            chk($sformatf("%s tx_ready ch%0d", s_pair(st) ? "R2" : "R3", c), 32'(tx_ready[c]), 32'(er));
        end
        for (int c = 0; c < 4; c++) begin
            int st = strm(chan_sel, c);
            if (s_tx(st)) begin
                if (tick) begin
                    logic [31:0] w;
                    logic [15:0] lo, hi;
                    if (s_pair(st)) begin
                        cur_a[c] = '0; cur_b[c] = '0;
                        if (wq[c].size() > 0) begin
                            w = wq[c].pop_front();
                            lo = big_endian ? w[31:16] : w[15:0];
                            hi = big_endian ? w[15:0] : w[31:16];
                            cur_a[c] = lo; cur_b[c] = hi;
                        end
                    end else begin
                        if (sq[c].size() == 0 && wq[c].size() > 0) begin
                            w = wq[c].pop_front();
                            sq[c].push_back(big_endian ? w[31:16] : w[15:0]);
                            sq[c].push_back(big_endian ? w[15:0] : w[31:16]);
                        end
                        cur_a[c] = (sq[c].size() > 0) ? sq[c].pop_front() : 16'h0;
                        cur_b[c] = '0;
                    end
                end
            end else begin
                bit take = !exp_rv[c] || rdy[c];
                logic [15:0] sa = rx_slot[(s_slota(st)-3)*20 + 4 +: 16];
                logic [15:0] sb = rx_slot[(s_slotb(st)-3)*20 + 4 +: 16];
                if (exp_rv[c] && rdy[c]) exp_rv[c] = 0;
                if (tick && take) begin
                    if (st == 5) begin exp_rw[c] = pk(sa, sb); exp_rv[c] = 1; end
                    else if (st == 6) begin exp_rw[c] = pk(sa, 16'h0); exp_rv[c] = 1; end
                    else begin
                        rq[c].push_back(sa);
                        if (rq[c].size() == 2) begin
                            exp_rw[c] = pk(rq[c][0], rq[c][1]);
                            rq[c].delete();
                            exp_rv[c] = 1;
                        end
                    end
                end
            end
        end
        @(negedge clk);
    endtask

    task automatic run_config(int sel, bit be);
        rst_n = 0; frame_tick = 0; tx_valid = '0; rx_ready = '0;
        chan_sel = 2'(sel); big_endian = be;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        for (int c = 0; c < 4; c++)
            for (int k = 0; k < 5; k++) wq[c].push_back($urandom);
        step(0, 4'h0, "R11 ");   // reset state
        for (int n = 0; n < 66; n++) begin
            logic [3:0] r = (n >= 20 && n < 36) ? 4'h0 : 4'($urandom | $urandom);
            step(n % 3 == 0, r);
        end
    endtask

    initial begin
        @(negedge clk);
        for (int be = 0; be < 2; be++)
            for (int sel = 0; sel < 4; sel++) run_config(sel, be[0]);
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule